// File: doc/BRIEF.md
# Nibble-Programmed Priority Interrupt Controller

This block merges 28 interrupt sources into one request to a processor: a 3-bit priority level and the 5-bit number of the source that owns it. Software programs each source through a 4-bit field in one of four 32-bit control registers. The low three bits of the field hold the priority, and priority 0 masks the source. The top bit of the field is a write qualifier. A field changes only when that bit is written as 1. Software can therefore re-prioritise, mask or unmask one source with a single store, and the other seven fields in the same word are left as they are.

Six of the sources are external pins. Each pin is synchronised, watched for one selectable edge, and remembered in a pending latch until software acknowledges it. The acknowledge is the same qualified write: writing the top bit of the field as 1 clears the latch. If the priority bits are written back unchanged, the acknowledge does not disturb the priority. The remaining 22 sources are level-sensitive and count as active only while their input is high. A separate register picks the active edge for each external pin.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every priority is 0, every pending latch is clear, all six edge-select bits read 1 (rising), and both outputs are 0.
- R2: Source s (1..28) owns register index (s-1)/8, at address (s-1)/8. Its field occupies bits [31-4*((s-1)%8) -: 4]: bit 3 of the field is the qualifier and bits 2:0 are the priority. When a write to that register has bit 3 of the field set, the priority takes bits 2:0. When bit 3 is clear, the field is unchanged.
- R3: A source with priority 0 never wins, even when it is active.
- R4: Every source other than 1, 2, 3, 4, 26 and 27 is level-sensitive. It is active exactly while its bit src_in[s-1] is high, and it keeps no memory once the input drops.
- R5: Sources 1, 2, 3, 4, 26 and 27 are external inputs 0..5. The selected edge on such an input sets a pending latch. The latch keeps the source active after the pin returns to its idle level.
- R6: A qualified write (bit 3 set) to an external source's field clears its pending latch. If bits 2:0 are written with the current value, the priority stays the same. If a new edge arrives in the same cycle, the edge wins.
- R7: Address 4 is the edge-select register, with bit k for external input k. A 1 selects the rising edge and a 0 selects the falling edge. Edges of the other polarity are ignored.
- R8: irq_level is the largest priority among active sources with a nonzero priority, and irq_src is that source's number.
- R9: When several active sources share the winning priority, the lowest-numbered one is reported.
- R10: Reading a control register returns, in each field, the priority in bits 2:0 and the live active state (pending latch or level input) in bit 3. Fields with no source, and addresses 5 to 7, read 0.
- R11: The outputs are registered. When no source qualifies, both outputs are 0, and source number 0 means spurious. A level input is reflected one clock after it is sampled. An external edge is reflected three clocks after it is sampled: one clock for the synchroniser, one for the latch and one for the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address: 0 to 3 control, 4 edge select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| src_in | input | 28 | Source inputs; bit s-1 is source s |
| irq_level | output | 3 | Winning priority, 0 when idle |
| irq_src | output | 5 | Winning source number, 0 when idle |

## Verification
The bench writes words whose other fields carry a cleared qualifier and nonzero priority bits. A design that ignored the qualifier would corrupt neighbouring priorities, and the readback would expose it. The bench creates a priority tie between two sources, to catch an arbiter that reports the higher number. It pulses an external pin briefly, so a design without a latch would drop the request. It then acknowledges the source with the priority written back unchanged, so a design whose acknowledge fails to clear the latch, or that rewrites the priority, shows up at the outputs and in the readback. Finally it flips an edge-select bit and drives the opposite transition, to catch a detector that fires on either edge or on the wrong one.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NUM_SRC     = 28;
    localparam int NUM_REG     = 4;
    localparam int FLD_PER_REG = 8;
    localparam int FLD_W       = 4;
    localparam int PRIO_W      = 3;
    localparam int NUM_EXT     = 6;
    localparam int DATA_W      = FLD_PER_REG * FLD_W;
    localparam int ADDR_W      = 3;
    localparam int SRC_W       = $clog2(NUM_SRC + 1);
    localparam int POL_ADDR    = NUM_REG;

    // zero-based source index of external input k
    function automatic int ext_to_src(int k);
        return (k < 4) ? k : k + 21;
    endfunction

    function automatic int src_reg(int s);
        return s / FLD_PER_REG;
    endfunction

    // msb (qualifier bit) of source s's field
    function automatic int src_msb(int s);
        return DATA_W - 1 - FLD_W * (s % FLD_PER_REG);
    endfunction

    typedef struct packed {
        logic s1;
        logic s2;
        logic pend;
    } edge_state_t;

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_EXT-1:0]             pol;
        logic [PRIO_W-1:0]              lvl;
        logic [SRC_W-1:0]               src;
    } ctrl_state_t;
endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    input  logic clr,
    output logic edge_hit,
    output logic pend
);
    import prio_irq_pkg::*;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        edge_hit  = rise_sel ? (st_q.s1 & ~st_q.s2) : (~st_q.s1 & st_q.s2);
        // a fresh edge has precedence over an acknowledge
        st_d.pend = edge_hit | (st_q.pend & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0]        active,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [PRIO_W-1:0]         win_lvl,
    output logic [SRC_W-1:0]          win_src
);
    always_comb begin
        win_lvl = '0;
        win_src = '0;
        // scan downward so an equal level from a lower number overwrites
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (active[s] && (prio_flat[s*PRIO_W +: PRIO_W] != '0) &&
                (prio_flat[s*PRIO_W +: PRIO_W] >= win_lvl)) begin
                win_lvl = prio_flat[s*PRIO_W +: PRIO_W];
                win_src = SRC_W'(s + 1);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_SRC-1:0]  src_in,
    output logic [PRIO_W-1:0]   irq_level,
    output logic [SRC_W-1:0]    irq_src
);
    ctrl_state_t st_d, st_q;

    logic [NUM_SRC-1:0]        fld_wr;
    logic [NUM_SRC-1:0]        src_active;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_EXT-1:0]        ext_pend;
    logic [NUM_EXT-1:0]        ext_clr;
    logic [NUM_EXT-1:0]        ext_edge;
    logic [PRIO_W-1:0]         win_lvl;
    logic [SRC_W-1:0]          win_src;

    // per-source qualified field write
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
        assign fld_wr[s] = wr_en && (addr == ADDR_W'(src_reg(s))) &&
                           wdata[src_msb(s)];
        assign prio_flat[s*PRIO_W +: PRIO_W] = st_q.prio[s];
    end

    // edge-sensitive channels
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        localparam int S = ext_to_src(k);
        assign ext_clr[k] = fld_wr[S];
        prio_irq_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (src_in[S]),
            .rise_sel (st_q.pol[k]),
            .clr      (ext_clr[k]),
            .edge_hit (ext_edge[k]),
            .pend     (ext_pend[k])
        );
    end

    always_comb begin
        src_active = src_in;
        for (int k = 0; k < NUM_EXT; k++)
            src_active[ext_to_src(k)] = ext_pend[k];
    end

    prio_irq_arbiter u_arb (
        .active    (src_active),
        .prio_flat (prio_flat),
        .win_lvl   (win_lvl),
        .win_src   (win_src)
    );

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (fld_wr[s])
                st_d.prio[s] = wdata[src_msb(s)-1 -: PRIO_W];
        end
        if (wr_en && (addr == ADDR_W'(POL_ADDR)))
            st_d.pol = wdata[NUM_EXT-1:0];
        st_d.lvl = win_lvl;
        st_d.src = win_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prio <= '0;
            st_q.pol  <= '1;
            st_q.lvl  <= '0;
            st_q.src  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (addr == ADDR_W'(src_reg(s)))
                rdata[src_msb(s) -: FLD_W] = {src_active[s], st_q.prio[s]};
        end
        if (addr == ADDR_W'(POL_ADDR))
            rdata[NUM_EXT-1:0] = st_q.pol;
    end

    assign irq_level = st_q.lvl;
    assign irq_src   = st_q.src;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [PRIO_W-1:0]           irq_level,
    input logic [SRC_W-1:0]            irq_src,
    input logic [NUM_EXT-1:0]          ext_pend,
    input logic [NUM_EXT-1:0]          ext_clr,
    input logic [NUM_EXT-1:0]          ext_edge,
    input logic [NUM_SRC*PRIO_W-1:0]   prio_flat
);
    assert_idle_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (irq_src == '0));

    assert_winner_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src != '0) |-> (irq_level != '0));

    assert_src_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_src <= SRC_W'(NUM_SRC));

    assert_prio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr < ADDR_W'(NUM_REG))) |=> $stable(prio_flat));

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_pend
        assert_pend_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_pend[k] && !ext_clr[k]) |=> ext_pend[k]);
        assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_clr[k] && !ext_edge[k]) |=> !ext_pend[k]);
        assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ext_edge[k] |=> ext_pend[k]);
    end
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .irq_level (irq_level),
    .irq_src   (irq_src),
    .ext_pend  (ext_pend),
    .ext_clr   (ext_clr),
    .ext_edge  (ext_edge),
    .prio_flat (prio_flat)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [27:0] src_in = 0;
    logic [2:0]  irq_level;
    logic [4:0]  irq_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] lvl;
        logic [4:0] src;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_in(src_in), .irq_level(irq_level), .irq_src(irq_src)
    );

    // monitor: compare queued expectations against the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (irq_level !== e.lvl || irq_src !== e.src) begin
                    errors++;
                    $display("FAIL %s: level/src got %0d/%0d expected %0d/%0d",
                             e.tag, irq_level, irq_src, e.lvl, e.src);
                end
            end
        end
    end

    task automatic expect_out(input logic [2:0] l, input logic [4:0] s, input string tag);
        exp_t e;
        repeat (4) @(negedge clk);
        e.lvl = l; e.src = s; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = 0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata got %h expected %h", tag, rdata, exp);
        end
    endtask

    task automatic set_in(input int idx, input logic v);
        @(negedge clk);
        src_in[idx] = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        expect_out(0, 0, "R1 reset outputs");
        rd_check(0, 32'h0, "R1 reset priorities");
        rd_check(4, 32'h3F, "R1 reset edge select");

        // R2/R4: source 5 prio 5 at bits 15:12 of reg 0
        wr(0, 32'h0000_D000);
        set_in(4, 1);
        expect_out(5, 5, "R4 level source active");
        rd_check(0, 32'h0000_D000, "R10 readback prio+live");
        // R2 qualifier clear: no change
        wr(0, 32'h7777_7777);
        rd_check(0, 32'h0000_D000, "R2 unqualified write ignored");
        // R8: source 9 prio 6
        wr(1, 32'hE000_0000);
        set_in(8, 1);
        expect_out(6, 9, "R8 higher priority wins");
        // R9 tie at level 5
        wr(1, 32'hD000_0000);
        expect_out(5, 5, "R9 tie lowest number");
        // R3 mask
        wr(0, 32'h0000_8000);
        expect_out(5, 9, "R3 masked source skipped");
        wr(1, 32'h8000_0000);
        expect_out(0, 0, "R3 all masked idle");
        set_in(8, 0);
        // R4 no memory
        wr(0, 32'h0000_B000);
        expect_out(3, 5, "R4 level prio 3");
        set_in(4, 0);
        expect_out(0, 0, "R4 level dropped");

        // R5 external source 1 (bits 31:28 reg 0), prio 7
        wr(0, 32'hF000_0000);
        set_in(0, 1);
        repeat (2) @(negedge clk);
        src_in[0] = 0;
        expect_out(7, 1, "R5 pending held after pulse");
        rd_check(0, 32'hF000_3000, "R5 readback pending");
        // R6 ack with same priority
        wr(0, 32'hF000_0000);
        expect_out(0, 0, "R6 ack clears pending");
        rd_check(0, 32'h7000_3000, "R6 priority kept");

        // R7 falling edge for external input 0
        wr(4, 32'h0000_003E);
        rd_check(4, 32'h3E, "R7 edge select readback");
        set_in(0, 1);
        expect_out(0, 0, "R7 rising ignored when falling selected");
        set_in(0, 0);
        expect_out(7, 1, "R7 falling edge latched");
        wr(0, 32'hF000_0000);
        expect_out(0, 0, "R6 second ack");

        // R12 mapping: external input 5 is source 27, reg 3 bits 23:20
        wr(3, 32'h00C0_000F);
        set_in(26, 1);
        set_in(26, 0);
        expect_out(4, 27, "R5 source 27 latched");
        rd_check(3, 32'h00C0_0000, "R10 reg3 readback, unused zero");
        rd_check(6, 32'h0, "R10 unmapped address");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule